// File: doc/BRIEF.md
# Compressed-Payload Non-Audio Detector

The detector watches the payload words that a receiver front end delivers from each decoded subframe and the channel-status blocks that it assembles. From these it decides whether the stream is plain linear PCM that a codec can play, or a compressed burst payload that must not reach the speakers. Two flags carry this decision. `pcm_n` is set when the payload shows the burst-preamble synchronisation pattern. `audio_n` copies the non-linear-PCM indicator from each completed channel-status block. `non_audio` is the OR of the two flags.

The pattern is six consecutive payload words, compared on their upper 16 bits: four words of zero, then the first preamble word 16'hF872, then the second preamble word 16'h4E1F. The matcher restarts correctly when candidates overlap. `pcm_n` clears again after a long run of payload words that contains no pattern.

Each edge of either flag can raise an active-low interrupt. The interrupt stays asserted until software sends a clear pulse, and each flag has its own mask. Biphase decoding, clock recovery and register access belong to other blocks.

Top module: `nonaudio_detect`

## Requirements
- R1: A valid word sequence whose upper 16 bits (word_data[23:8]) read 0, 0, 0, 0, 16'hF872, 16'h4E1F sets `pcm_n` at the clock edge that takes the last word. The lower 8 bits of every word play no part in the match.
- R2: The matcher re-synchronises on overlapping candidates. More than four zero words before the first preamble word still match. A failed candidate whose trailing zeros begin a new run also matches, for example 0,0,0,0,F872,0,0,0,0,F872,4E1F.
- R3: A corrupted or short candidate does not set `pcm_n`. This covers fewer than four zero words, a wrong first preamble word and a wrong second preamble word.
- R4: While `pcm_n` is 1, each valid word that completes no pattern adds one to a count. `pcm_n` returns to 0 at the 4096th such word. Any completed pattern resets the count to zero.
- R5: At a clock edge where `cs_done` is high, `audio_n` takes `cs_block[1]`. At every other edge `audio_n` holds its value, whatever `cs_block` shows.
- R6: `non_audio` equals `pcm_n` OR `audio_n` at all times.
- R7: A change of `pcm_n` or `audio_n`, in either direction, drives `irq_n` low at the same clock edge when that flag's mask is 0.
- R8: While `mask_pcm` is 1, changes of `pcm_n` do not raise the interrupt. While `mask_audio` is 1, changes of `audio_n` do not raise it. Each mask affects only its own flag.
- R9: `irq_n` stays low until a cycle with `irq_clear` high. If an unmasked change happens in that same cycle, `irq_n` stays low.
- R10: While `rst` is high, `pcm_n` and `audio_n` go to 0 at each clock edge, the timeout count and the partial pattern are discarded, and `irq_n` goes to 1.
- R11: Cycles with `word_valid` low do not advance the matcher or the timeout count, and they do not break a pattern that is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | Strobe: `word_data` holds a payload word |
| word_data | input | 24 | Payload word; the upper 16 bits are compared |
| cs_done | input | 1 | Strobe: `cs_block` holds a completed channel-status block |
| cs_block | input | 192 | Assembled channel-status block, bit 0 first |
| mask_audio | input | 1 | 1 stops `audio_n` changes from raising the interrupt |
| mask_pcm | input | 1 | 1 stops `pcm_n` changes from raising the interrupt |
| irq_clear | input | 1 | One-cycle pulse that clears a pending interrupt |
| pcm_n | output | 1 | Burst-preamble pattern seen recently |
| audio_n | output | 1 | Channel status reports non-linear-PCM |
| non_audio | output | 1 | OR of `pcm_n` and `audio_n` |
| irq_n | output | 1 | Active-low update interrupt |

## Verification
A matcher that holds the wrong partial-pattern state shows up at `pcm_n` one edge after the final preamble word. It either misses the pattern or sets the flag on a corrupted candidate. A wrong timeout count shows up only at the end of the silent window, so that boundary is tested one word before and exactly at the 4096th word. Errors in the mask or clear logic show up at `irq_n` on the same edge as the flag change.

// File: rtl/nad_pkg.sv
package nad_pkg;

  typedef logic [3:0] sync_state_t;

  localparam logic [15:0] PRE_A = 16'hF872;
  localparam logic [15:0] PRE_B = 16'h4E1F;

  // States 0..zr count zero words (saturating at zr); zr+1 means first preamble seen.
  function automatic sync_state_t sync_step(input sync_state_t st,
                                            input logic [15:0] up,
                                            input sync_state_t zr);
    sync_state_t r;
    if (st == zr + 4'd1)
      r = (up == 16'h0) ? 4'd1 : 4'd0;
    else if (up == 16'h0)
      r = (st == zr) ? zr : st + 4'd1;
    else if (st == zr && up == PRE_A)
      r = zr + 4'd1;
    else
      r = '0;
    return r;
  endfunction

  function automatic logic sync_hit(input sync_state_t st,
                                    input logic [15:0] up,
                                    input sync_state_t zr);
    return (st == zr + 4'd1) && (up == PRE_B);
  endfunction

  function automatic logic irq_next(input logic pend, input logic clr,
                                    input logic chg_p, input logic msk_p,
                                    input logic chg_a, input logic msk_a);
    return (pend & ~clr) | (chg_p & ~msk_p) | (chg_a & ~msk_a);
  endfunction

endpackage

// File: rtl/nad_sync_matcher.sv
module nad_sync_matcher
  import nad_pkg::*;
#(
  parameter int ZERO_RUN = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        word_valid,
  input  logic [15:0] word_upper,
  output logic        hit
);
  localparam sync_state_t ZR = sync_state_t'(ZERO_RUN);

  sync_state_t st_q;

  assign hit = word_valid & sync_hit(st_q, word_upper, ZR);

  always_ff @(posedge clk) begin
    if (rst)
      st_q <= '0;
    else if (word_valid)
      st_q <= sync_step(st_q, word_upper, ZR);
  end
endmodule

// File: rtl/nad_pcm_flag.sv
module nad_pcm_flag #(
  parameter int TIMEOUT_WORDS = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic word_valid,
  input  logic hit,
  output logic pcm_n,
  output logic pcm_chg
);
  localparam int CW = $clog2(TIMEOUT_WORDS);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_WORDS - 1);

  logic          flag_q, flag_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    flag_d = flag_q;
    cnt_d  = cnt_q;
    if (word_valid) begin
      if (hit) begin
        flag_d = 1'b1;
        cnt_d  = '0;
      end else if (flag_q) begin
        if (cnt_q == LAST) begin
          flag_d = 1'b0;
          cnt_d  = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  assign pcm_chg = flag_d ^ flag_q;
  assign pcm_n   = flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      flag_q <= flag_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/nad_cs_flag.sv
module nad_cs_flag #(
  parameter int CS_BITS  = 192,
  parameter int FLAG_BIT = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_done,
  input  logic [CS_BITS-1:0] cs_block,
  output logic               audio_n,
  output logic               audio_chg
);
  logic flag_q;

  assign audio_chg = cs_done & (cs_block[FLAG_BIT] ^ flag_q);
  assign audio_n   = flag_q;

  always_ff @(posedge clk) begin
    if (rst)
      flag_q <= 1'b0;
    else if (cs_done)
      flag_q <= cs_block[FLAG_BIT];
  end
endmodule

// File: rtl/nad_irq.sv
module nad_irq
  import nad_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pcm_chg,
  input  logic audio_chg,
  input  logic mask_pcm,
  input  logic mask_audio,
  input  logic irq_clear,
  output logic irq_evt,
  output logic irq_n
);
  logic pend_q;

  assign irq_evt = (pcm_chg & ~mask_pcm) | (audio_chg & ~mask_audio);
  assign irq_n   = ~pend_q;

  always_ff @(posedge clk) begin
    if (rst)
      pend_q <= 1'b0;
    else
      pend_q <= irq_next(pend_q, irq_clear, pcm_chg, mask_pcm, audio_chg, mask_audio);
  end
endmodule

// File: rtl/nonaudio_detect.sv
module nonaudio_detect #(
  parameter int WORD_W        = 24,
  parameter int CS_BITS       = 192,
  parameter int AUDIO_BIT     = 1,
  parameter int ZERO_RUN      = 4,
  parameter int TIMEOUT_WORDS = 4096
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               word_valid,
  input  logic [WORD_W-1:0]  word_data,
  input  logic               cs_done,
  input  logic [CS_BITS-1:0] cs_block,
  input  logic               mask_audio,
  input  logic               mask_pcm,
  input  logic               irq_clear,
  output logic               pcm_n,
  output logic               audio_n,
  output logic               non_audio,
  output logic               irq_n
);
  logic [15:0] word_upper;
  logic        sync_hit_w;
  logic        pcm_chg;
  logic        audio_chg;
  logic        irq_evt;
  logic        unused_rest;

  assign word_upper  = word_data[WORD_W-1 -: 16];
  assign unused_rest = ^word_data ^ ^cs_block;

  nad_sync_matcher #(.ZERO_RUN(ZERO_RUN)) i_match (
    .clk(clk), .rst(rst), .word_valid(word_valid),
    .word_upper(word_upper), .hit(sync_hit_w)
  );

  nad_pcm_flag #(.TIMEOUT_WORDS(TIMEOUT_WORDS)) i_pcm (
    .clk(clk), .rst(rst), .word_valid(word_valid), .hit(sync_hit_w),
    .pcm_n(pcm_n), .pcm_chg(pcm_chg)
  );

  nad_cs_flag #(.CS_BITS(CS_BITS), .FLAG_BIT(AUDIO_BIT)) i_cs (
    .clk(clk), .rst(rst), .cs_done(cs_done), .cs_block(cs_block),
    .audio_n(audio_n), .audio_chg(audio_chg)
  );

  nad_irq i_irq (
    .clk(clk), .rst(rst), .pcm_chg(pcm_chg), .audio_chg(audio_chg),
    .mask_pcm(mask_pcm), .mask_audio(mask_audio), .irq_clear(irq_clear),
    .irq_evt(irq_evt), .irq_n(irq_n)
  );

  assign non_audio = pcm_n | audio_n;
endmodule

// File: rtl/nad_checker.sv
module nad_checker #(
  parameter int CS_BITS   = 192,
  parameter int AUDIO_BIT = 1
) (
  input logic               clk,
  input logic               rst,
  input logic               word_valid,
  input logic               cs_done,
  input logic [CS_BITS-1:0] cs_block,
  input logic               mask_audio,
  input logic               mask_pcm,
  input logic               irq_clear,
  input logic               sync_hit_w,
  input logic               pcm_chg,
  input logic               pcm_n,
  input logic               audio_n,
  input logic               non_audio,
  input logic               irq_n
);
  assert_sync_sets_R1: assert property (@(posedge clk) disable iff (rst)
    sync_hit_w |=> pcm_n);

  assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
    cs_done |=> (audio_n == $past(cs_block[AUDIO_BIT])));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !cs_done |=> $stable(audio_n));

  assert_or_R6: assert property (@(posedge clk) disable iff (rst)
    non_audio == (pcm_n | audio_n));

  assert_raise_R7: assert property (@(posedge clk) disable iff (rst)
    (pcm_chg && !mask_pcm) |=> !irq_n);

  assert_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> (($past(pcm_n) != pcm_n) && !$past(mask_pcm)) ||
                     (($past(audio_n) != audio_n) && !$past(mask_audio)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && !irq_clear) |=> !irq_n);

  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !word_valid |=> $stable(pcm_n));

  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (!pcm_n && !audio_n && irq_n));
endmodule

bind nonaudio_detect nad_checker #(.CS_BITS(CS_BITS), .AUDIO_BIT(AUDIO_BIT)) i_chk (
  .clk(clk), .rst(rst), .word_valid(word_valid), .cs_done(cs_done),
  .cs_block(cs_block), .mask_audio(mask_audio), .mask_pcm(mask_pcm),
  .irq_clear(irq_clear), .sync_hit_w(sync_hit_w), .pcm_chg(pcm_chg),
  .pcm_n(pcm_n), .audio_n(audio_n), .non_audio(non_audio), .irq_n(irq_n)
);

// File: tb/test_nonaudio_detect.sv
module test_nonaudio_detect;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         word_valid = 1'b0;
  logic [23:0]  word_data = '0;
  logic         cs_done = 1'b0;
  logic [191:0] cs_block = '0;
  logic         mask_audio = 1'b0;
  logic         mask_pcm = 1'b0;
  logic         irq_clear = 1'b0;
  logic         pcm_n, audio_n, non_audio, irq_n;

  always #2.5 clk = ~clk;

  nonaudio_detect i_nonaudio_detect (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_data(word_data),
    .cs_done(cs_done), .cs_block(cs_block), .mask_audio(mask_audio),
    .mask_pcm(mask_pcm), .irq_clear(irq_clear), .pcm_n(pcm_n),
    .audio_n(audio_n), .non_audio(non_audio), .irq_n(irq_n)
  );

  typedef struct {
    string req;
    logic  pcm;
    logic  aud;
    logic  irqn;
  } exp_t;

  exp_t q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  // reference state
  logic [15:0] hist[6];
  logic m_pcm, m_aud, m_pend;
  int   m_cnt;
  logic [7:0] low_seed = 8'h3C;

  function automatic logic [191:0] mk_cs(input logic b);
    return {{95{2'b10}}, b, ~b};
  endfunction

  task automatic push(input string req);
    exp_t e;
    e.req = req; e.pcm = m_pcm; e.aud = m_aud; e.irqn = ~m_pend;
    q.push_back(e);
  endtask

  task automatic step(input logic wv, input logic [15:0] up, input logic csd,
                      input logic csb, input logic clr, input string req);
    logic p0, a0, match;
    word_valid = wv;
    low_seed   = {low_seed[6:0], low_seed[7] ^ low_seed[5]};
    word_data  = {up, low_seed};
    cs_done    = csd;
    cs_block   = mk_cs(csb);
    irq_clear  = clr;
    p0 = m_pcm; a0 = m_aud;
    if (wv) begin
      for (int i = 0; i < 5; i++) hist[i] = hist[i+1];
      hist[5] = up;
      match = (hist[0] == 0) && (hist[1] == 0) && (hist[2] == 0) && (hist[3] == 0) &&
              (hist[4] == 16'hF872) && (hist[5] == 16'h4E1F);
      if (match) begin
        m_pcm = 1'b1; m_cnt = 0;
      end else if (m_pcm) begin
        m_cnt++;
        if (m_cnt == 4096) begin m_pcm = 1'b0; m_cnt = 0; end
      end
    end
    if (csd) m_aud = csb;
    m_pend = (m_pend & ~clr) | ((p0 != m_pcm) & ~mask_pcm) | ((a0 != m_aud) & ~mask_audio);
    push(req);
    @(posedge clk); #3;
  endtask

  task automatic do_reset(input string req);
    rst = 1'b1; word_valid = 0; cs_done = 0; irq_clear = 0;
    for (int i = 0; i < 6; i++) hist[i] = 16'hFFFF;
    m_pcm = 0; m_aud = 0; m_pend = 0; m_cnt = 0;
    push(req);
    @(posedge clk); #3;
    rst = 1'b0;
  endtask

  task automatic wd(input logic [15:0] up, input string req);
    step(1'b1, up, 1'b0, m_aud, 1'b0, req);
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(1'b0, 16'h4E1F, 1'b0, ~m_aud, 1'b0, req);
  endtask

  task automatic clear_irq(input string req);
    step(1'b0, 16'h0, 1'b0, m_aud, 1'b1, req);
  endtask

  task automatic burst(input string req);
    for (int i = 0; i < 4; i++) wd(16'h0000, req);
    wd(16'hF872, req);
    wd(16'h4E1F, req);
  endtask

  task automatic cs(input logic b, input string req);
    step(1'b0, 16'h0, 1'b1, b, 1'b0, req);
  endtask

  // monitor: compares each registered result after the edge it belongs to
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (pcm_n !== e.pcm) begin
        n_bad++; $display("FAIL %s pcm_n act=%b exp=%b", e.req, pcm_n, e.pcm);
      end
      if (audio_n !== e.aud) begin
        n_bad++; $display("FAIL %s audio_n act=%b exp=%b", e.req, audio_n, e.aud);
      end
      if (irq_n !== e.irqn) begin
        n_bad++; $display("FAIL %s irq_n act=%b exp=%b", e.req, irq_n, e.irqn);
      end
      if (non_audio !== (e.pcm | e.aud)) begin
        n_bad++; $display("FAIL R6 non_audio act=%b exp=%b", non_audio, e.pcm | e.aud);
      end
    end
  end

  initial begin
    #(5 * 60000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #3;
    do_reset("R10");
    idle(3, "R10");
    // R1: basic pattern, R7 rise
    burst("R1");
    idle(2, "R7");
    clear_irq("R9");
    idle(2, "R9");
    // R3: corrupted candidates
    do_reset("R10");
    for (int i = 0; i < 3; i++) wd(16'h0, "R3");
    wd(16'hF872, "R3"); wd(16'h4E1F, "R3");
    for (int i = 0; i < 4; i++) wd(16'h0, "R3");
    wd(16'hF873, "R3"); wd(16'h4E1F, "R3");
    for (int i = 0; i < 4; i++) wd(16'h0, "R3");
    wd(16'hF872, "R3"); wd(16'h4E1E, "R3");
    for (int i = 0; i < 4; i++) wd(16'h0, "R3");
    wd(16'hF872, "R3"); wd(16'hF872, "R3"); wd(16'h4E1F, "R3");
    idle(2, "R3");
    // R2: overlapping candidates
    for (int i = 0; i < 7; i++) wd(16'h0, "R2");
    wd(16'hF872, "R2"); wd(16'h4E1F, "R2");
    idle(1, "R2");
    do_reset("R10");
    for (int i = 0; i < 4; i++) wd(16'h0, "R2");
    wd(16'hF872, "R2");
    for (int i = 0; i < 4; i++) wd(16'h0, "R2");
    wd(16'hF872, "R2"); wd(16'h4E1F, "R2");
    idle(1, "R2");
    // R11: gaps inside a pattern
    do_reset("R10");
    wd(16'h0, "R11"); idle(2, "R11"); wd(16'h0, "R11"); wd(16'h0, "R11");
    idle(1, "R11"); wd(16'h0, "R11"); idle(3, "R11");
    wd(16'hF872, "R11"); idle(2, "R11"); wd(16'h4E1F, "R11");
    idle(5, "R11");
    // R4: timeout boundary, then restart by a new match
    for (int i = 0; i < 4094; i++) wd(16'h1234, "R4");
    idle(3, "R4");
    wd(16'h1234, "R4");
    wd(16'h1234, "R4");
    idle(2, "R4");
    clear_irq("R9");
    burst("R4");
    for (int i = 0; i < 3000; i++) wd(16'h00AA, "R4");
    burst("R4");
    for (int i = 0; i < 3000; i++) wd(16'h00AA, "R4");
    idle(2, "R4");
    // R5: channel status capture and hold
    do_reset("R10");
    step(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, "R5");
    step(1'b0, 16'h0, 1'b0, 1'b1, 1'b0, "R5");
    cs(1'b1, "R5");
    idle(2, "R7");
    clear_irq("R9");
    cs(1'b1, "R5");
    idle(2, "R5");
    cs(1'b0, "R5");
    idle(1, "R7");
    // R8: masks
    do_reset("R10");
    mask_audio = 1'b1;
    cs(1'b1, "R8"); idle(2, "R8");
    cs(1'b0, "R8"); idle(1, "R8");
    burst("R8"); idle(2, "R8");
    clear_irq("R9");
    mask_audio = 1'b0; mask_pcm = 1'b1;
    do_reset("R10");
    burst("R8"); idle(2, "R8");
    cs(1'b1, "R8"); idle(2, "R8");
    mask_pcm = 1'b0;
    // R9: clear with concurrent event keeps interrupt
    clear_irq("R9");
    idle(1, "R9");
    cs(1'b0, "R9");
    step(1'b0, 16'h0, 1'b1, 1'b1, 1'b1, "R9");
    idle(2, "R9");
    clear_irq("R9");
    idle(2, "R9");
    // R10: reset with state pending
    burst("R10");
    do_reset("R10");
    idle(2, "R10");
    @(posedge clk); #3;
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule